// File: doc/BRIEF.md
# Multi-Slot In-Order Retirement Queue

This block follows instructions from dispatch until they leave the machine in program order. A dispatched instruction carries a tag and a micro-op count. The block checks that there is enough capacity, writes the instruction into a circular slot array, and hands back a token. The token is the index of the slot where the instruction starts. The execution side later reports completion by quoting that token. Instructions at the head of the array leave in program order, and only after they have completed. On leaving, an instruction returns its capacity and its slot is emptied.

The slot array holds twice as many positions as there are capacity entries. An instruction with several micro-ops takes one position per micro-op. An instruction with no micro-ops still takes one position, but no capacity. The head pointer steps over all the positions that the retiring instruction occupies.

Dispatch is a valid/ready stream. An instruction is accepted on a clock edge where `disp_valid` and `disp_ready` are both high. `disp_ready` depends on the requested count, so the source keeps `disp_tag` and `disp_uops` steady while it waits. It may also withdraw the request. `disp_token` is valid in the same cycle as the handshake. Completion is a plain pulse with no back-pressure. Retirement is a notification stream with no back-pressure: the lanes that are raised in a cycle retire at the next edge, whatever the receiver does.

Top module: `retire_queue`

## Requirements
- R1: After reset, `free_count` equals ENTRIES, no `ret_valid` lane is raised, `disp_token` is 0, and `disp_ready` is high for any count of 1 to ENTRIES.
- R2: A dispatch is accepted only when `free_count` is at least `disp_uops` and the occupied slot positions plus max(1, `disp_uops`) do not exceed 2×ENTRIES. Otherwise `disp_ready` is low and holding the request changes nothing. A count above ENTRIES is never accepted.
- R3: `disp_token` is the slot index where the next instruction is written. After each accepted dispatch it advances by max(1, count) modulo 2×ENTRIES, and it does not move otherwise.
- R4: An accepted dispatch lowers `free_count` by its micro-op count. A retirement raises `free_count` by that instruction's micro-op count. A zero-count instruction leaves `free_count` unchanged.
- R5: A completion pulse (`cmp_valid`) carrying a token marks that instruction as executed. A completion in the same cycle as the dispatch of that same token also counts. A completion that names no dispatched instruction is ignored.
- R6: Instructions retire strictly in dispatch order. The head retires only once it has executed, and retirement within a cycle stops at the first instruction that has not executed. `ret_valid` lanes are raised from lane 0 upward with no gaps, and lane i carries the i-th retiring instruction's tag and count.
- R7: At most RET_MAX instructions retire per cycle. With RET_MAX = 0 there is no per-cycle limit beyond the slot array size.
- R8: A zero-count instruction occupies one slot position. With ENTRIES = 8, sixteen such instructions fill the array, and a seventeenth stalls while `free_count` is still 8.
- R9: With ENTRIES = 0, `disp_ready` is always high, `disp_token` is all ones (the unhandled value), and nothing is tracked or retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Dispatch can be accepted |
| disp_tag | input | TAG_W | Instruction tag |
| disp_uops | input | UOP_W | Micro-op count of the instruction |
| disp_token | output | TOK_W | Token for the instruction being dispatched |
| cmp_valid | input | 1 | Execution-complete pulse |
| cmp_token | input | TOK_W | Token of the completed instruction |
| ret_valid | output | LANES | Per-lane retirement this cycle, filled from lane 0 |
| ret_tag | output | LANES*TAG_W | Tag of each retiring lane |
| ret_uops | output | LANES*UOP_W | Micro-op count of each retiring lane |
| free_count | output | UOP_W | Free capacity entries |

## Verification
The hardest state to reach is a full slot array with capacity still free. Only zero-count instructions lead there, and the stimulus reaches it by dispatching sixteen of them with no completions and then offering a seventeenth. Completing those sixteen in reverse order keeps the head blocked until the last pulse. At that point a long run of executed entries is released at once, which exercises the per-cycle limit and the wrap of the head pointer. The bench also lands a completion on the very edge where its instruction is dispatched, to reach the same-cycle case.

// File: rtl/rq_pkg.sv
package rq_pkg;

  typedef struct packed {
    logic valid;
    logic exec;
  } rq_flags_t;

  function automatic int rq_lanes(input int ret_max, input int slots);
    return (ret_max <= 0 || ret_max > slots) ? slots : ret_max;
  endfunction

endpackage

// File: rtl/rq_slot_array.sv
module rq_slot_array
  import rq_pkg::*;
#(
  parameter int SLOTS  = 16,
  parameter int SLOT_W = 4,
  parameter int TAG_W  = 8,
  parameter int UOP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [UOP_W-1:0]  wr_uops,
  input  logic              wr_exec,
  input  logic              set_en,
  input  logic [SLOT_W-1:0] set_idx,
  input  logic [SLOTS-1:0]  clr,
  output rq_flags_t         flags [SLOTS],
  output logic [TAG_W-1:0]  tags  [SLOTS],
  output logic [UOP_W-1:0]  uops  [SLOTS]
);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    rq_flags_t         f_q;
    logic [TAG_W-1:0]  t_q;
    logic [UOP_W-1:0]  u_q;
    logic              hit_wr, hit_set;

    assign hit_wr  = wr_en && (wr_idx == SLOT_W'(s));
    assign hit_set = set_en && (set_idx == SLOT_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        f_q <= '0;
        t_q <= '0;
        u_q <= '0;
      end else if (clr[s]) begin
        f_q <= '0;
        t_q <= '0;
        u_q <= '0;
      end else if (hit_wr) begin
        f_q <= '{valid: 1'b1, exec: wr_exec};
        t_q <= wr_tag;
        u_q <= wr_uops;
      end else if (hit_set && f_q.valid) begin
        f_q.exec <= 1'b1;
      end
    end

    assign flags[s] = f_q;
    assign tags[s]  = t_q;
    assign uops[s]  = u_q;
  end

endmodule

// File: rtl/rq_retire_select.sv
module rq_retire_select
  import rq_pkg::*;
#(
  parameter int SLOTS  = 16,
  parameter int SLOT_W = 4,
  parameter int UOP_W  = 4,
  parameter int LANES  = 2,
  parameter int SCNT_W = 5
) (
  input  rq_flags_t         flags [SLOTS],
  input  logic [UOP_W-1:0]  uops  [SLOTS],
  input  logic [SLOT_W-1:0] head,
  output logic [LANES-1:0]  lane_valid,
  output logic [SLOT_W-1:0] lane_idx [LANES],
  output logic [UOP_W-1:0]  uop_sum,
  output logic [SCNT_W-1:0] slot_sum,
  output logic [SLOT_W-1:0] head_nxt
);

  localparam int PW = SLOT_W + 1;

  always_comb begin
    logic [PW-1:0]    p;
    logic             run;
    logic [UOP_W-1:0] step;
    p        = PW'(head);
    run      = 1'b1;
    uop_sum  = '0;
    slot_sum = '0;
    for (int i = 0; i < LANES; i++) begin
      step          = '0;
      lane_idx[i]   = p[SLOT_W-1:0];
      lane_valid[i] = 1'b0;
      if (run && flags[p[SLOT_W-1:0]].valid && flags[p[SLOT_W-1:0]].exec) begin
        lane_valid[i] = 1'b1;
        step     = (uops[p[SLOT_W-1:0]] == '0) ? UOP_W'(1) : uops[p[SLOT_W-1:0]];
        uop_sum  = uop_sum + uops[p[SLOT_W-1:0]];
        slot_sum = slot_sum + SCNT_W'(step);
        p        = p + PW'(step);
        if (p >= PW'(SLOTS)) p = p - PW'(SLOTS);
      end else begin
        run = 1'b0;
      end
    end
    head_nxt = p[SLOT_W-1:0];
  end

endmodule

// File: rtl/rq_credit.sv
module rq_credit #(
  parameter int ENTRIES = 8,
  parameter int SLOTS   = 16,
  parameter int UOP_W   = 4,
  parameter int SCNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [UOP_W-1:0]  req_uops,
  input  logic              disp_fire,
  input  logic [UOP_W-1:0]  ret_uops,
  input  logic [SCNT_W-1:0] ret_slots,
  output logic              ready,
  output logic [UOP_W-1:0]  free
);

  localparam int CW = SCNT_W + 1;

  logic [UOP_W-1:0]  free_q;
  logic [SCNT_W-1:0] used_q;
  logic [UOP_W-1:0]  step;
  logic              room;

  assign step  = (req_uops == '0) ? UOP_W'(1) : req_uops;
  assign room  = (CW'(used_q) + CW'(step)) <= CW'(SLOTS);
  assign ready = (free_q >= req_uops) && room;
  assign free  = free_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= UOP_W'(ENTRIES);
      used_q <= '0;
    end else begin
      free_q <= free_q - (disp_fire ? req_uops : '0) + ret_uops;
      used_q <= used_q - ret_slots + (disp_fire ? SCNT_W'(step) : '0);
    end
  end

endmodule

// File: rtl/retire_queue.sv
module retire_queue
  import rq_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 8,
  parameter int RET_MAX = 2,
  localparam int SLOTS  = (ENTRIES == 0) ? 2 : 2 * ENTRIES,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int TOK_W  = SLOT_W + 1,
  localparam int UOP_W  = (ENTRIES < 1) ? 1 : $clog2(ENTRIES + 1),
  localparam int LANES  = rq_lanes(RET_MAX, SLOTS),
  localparam int SCNT_W = $clog2(SLOTS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   disp_valid,
  output logic                   disp_ready,
  input  logic [TAG_W-1:0]       disp_tag,
  input  logic [UOP_W-1:0]       disp_uops,
  output logic [TOK_W-1:0]       disp_token,
  input  logic                   cmp_valid,
  input  logic [TOK_W-1:0]       cmp_token,
  output logic [LANES-1:0]       ret_valid,
  output logic [LANES*TAG_W-1:0] ret_tag,
  output logic [LANES*UOP_W-1:0] ret_uops,
  output logic [UOP_W-1:0]       free_count
);

  if (ENTRIES == 0) begin : g_none
    assign disp_ready = 1'b1;
    assign disp_token = '1;
    assign ret_valid  = '0;
    assign ret_tag    = '0;
    assign ret_uops   = '0;
    assign free_count = '0;
  end else begin : g_core
    localparam int PW = SLOT_W + 1;

    logic [SLOT_W-1:0] head_q, tail_q, tail_nxt, head_nxt;
    logic [UOP_W-1:0]  disp_step;
    logic [PW-1:0]     tail_sum;
    logic              disp_fire, cmp_hit, cmp_same;
    logic [SLOT_W-1:0] cmp_idx;
    rq_flags_t         flags [SLOTS];
    logic [TAG_W-1:0]  tags  [SLOTS];
    logic [UOP_W-1:0]  uops  [SLOTS];
    logic [SLOT_W-1:0] lane_idx [LANES];
    logic [UOP_W-1:0]  ret_uop_sum;
    logic [SCNT_W-1:0] ret_slot_sum;
    logic [SLOTS-1:0]  clr;

    assign disp_fire = disp_valid && disp_ready;
    assign disp_step = (disp_uops == '0) ? UOP_W'(1) : disp_uops;
    assign tail_sum  = PW'(tail_q) + PW'(disp_step);
    assign tail_nxt  = (tail_sum >= PW'(SLOTS)) ? SLOT_W'(tail_sum - PW'(SLOTS))
                                                : tail_sum[SLOT_W-1:0];
    assign cmp_hit   = cmp_valid && (cmp_token < TOK_W'(SLOTS));
    assign cmp_idx   = cmp_token[SLOT_W-1:0];
    assign cmp_same  = disp_fire && cmp_hit && (cmp_idx == tail_q);
    assign disp_token = {1'b0, tail_q};

    rq_credit #(
      .ENTRIES(ENTRIES), .SLOTS(SLOTS), .UOP_W(UOP_W), .SCNT_W(SCNT_W)
    ) u_credit (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_uops  (disp_uops),
      .disp_fire (disp_fire),
      .ret_uops  (ret_uop_sum),
      .ret_slots (ret_slot_sum),
      .ready     (disp_ready),
      .free      (free_count)
    );

    rq_slot_array #(
      .SLOTS(SLOTS), .SLOT_W(SLOT_W), .TAG_W(TAG_W), .UOP_W(UOP_W)
    ) u_slots (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (disp_fire),
      .wr_idx  (tail_q),
      .wr_tag  (disp_tag),
      .wr_uops (disp_uops),
      .wr_exec (cmp_same),
      .set_en  (cmp_hit),
      .set_idx (cmp_idx),
      .clr     (clr),
      .flags   (flags),
      .tags    (tags),
      .uops    (uops)
    );

    rq_retire_select #(
      .SLOTS(SLOTS), .SLOT_W(SLOT_W), .UOP_W(UOP_W), .LANES(LANES), .SCNT_W(SCNT_W)
    ) u_sel (
      .flags      (flags),
      .uops       (uops),
      .head       (head_q),
      .lane_valid (ret_valid),
      .lane_idx   (lane_idx),
      .uop_sum    (ret_uop_sum),
      .slot_sum   (ret_slot_sum),
      .head_nxt   (head_nxt)
    );

    always_comb begin
      clr = '0;
      for (int i = 0; i < LANES; i++) begin
        if (ret_valid[i]) clr[lane_idx[i]] = 1'b1;
      end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign ret_tag[l*TAG_W +: TAG_W]  = ret_valid[l] ? tags[lane_idx[l]] : '0;
      assign ret_uops[l*UOP_W +: UOP_W] = ret_valid[l] ? uops[lane_idx[l]] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        head_q <= '0;
        tail_q <= '0;
      end else begin
        if (disp_fire) tail_q <= tail_nxt;
        head_q <= head_nxt;
      end
    end
  end

endmodule

// File: rtl/rq_checker.sv
module rq_checker
  import rq_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 8,
  parameter int RET_MAX = 2,
  localparam int SLOTS  = (ENTRIES == 0) ? 2 : 2 * ENTRIES,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int TOK_W  = SLOT_W + 1,
  localparam int UOP_W  = (ENTRIES < 1) ? 1 : $clog2(ENTRIES + 1),
  localparam int LANES  = rq_lanes(RET_MAX, SLOTS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   disp_valid,
  input logic                   disp_ready,
  input logic [TAG_W-1:0]       disp_tag,
  input logic [UOP_W-1:0]       disp_uops,
  input logic [TOK_W-1:0]       disp_token,
  input logic                   cmp_valid,
  input logic [TOK_W-1:0]       cmp_token,
  input logic [LANES-1:0]       ret_valid,
  input logic [LANES*TAG_W-1:0] ret_tag,
  input logic [LANES*UOP_W-1:0] ret_uops,
  input logic [UOP_W-1:0]       free_count
);

  logic             fire;
  logic [TOK_W:0]   tok_sum;
  logic [TOK_W-1:0] tok_next;
  logic [UOP_W:0]   ret_sum;

  assign fire    = disp_valid && disp_ready;
  assign tok_sum = (TOK_W+1)'(disp_token) + (TOK_W+1)'((disp_uops == '0) ? UOP_W'(1) : disp_uops);
  assign tok_next = (tok_sum >= (TOK_W+1)'(SLOTS)) ? TOK_W'(tok_sum - (TOK_W+1)'(SLOTS))
                                                   : TOK_W'(tok_sum);

  always_comb begin
    ret_sum = '0;
    for (int i = 0; i < LANES; i++) ret_sum = ret_sum + (UOP_W+1)'(ret_uops[i*UOP_W +: UOP_W]);
  end

  if (ENTRIES > 0) begin : g_on
    a_r2_credit_respected: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> (disp_uops <= free_count));

    a_r4_free_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      free_count <= UOP_W'(ENTRIES));

    a_r4_free_accounting: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((UOP_W+1)'(free_count) == (UOP_W+1)'($past(free_count))
                 - (UOP_W+1)'($past(fire) ? $past(disp_uops) : '0) + $past(ret_sum)));

    a_r3_token_step: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (disp_token == $past(tok_next)));

    a_r3_token_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(disp_token));

    a_r6_lanes_packed: assert property (@(posedge clk) disable iff (!rst_n)
      ((ret_valid + LANES'(1)) & ret_valid) == '0);
  end else begin : g_off
    a_r9_unhandled_token: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_token == '1) && disp_ready && (ret_valid == '0));
  end

endmodule

bind retire_queue rq_checker #(
  .ENTRIES(ENTRIES), .TAG_W(TAG_W), .RET_MAX(RET_MAX)
) u_rq_checker (.*);

// File: tb/retire_queue_bench.sv
module retire_queue_bench;

  localparam int N = 8;
  localparam int SL = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        disp_valid = 1'b0;
  logic        disp_ready;
  logic [7:0]  disp_tag = '0;
  logic [3:0]  disp_uops = '0;
  logic [4:0]  disp_token;
  logic        cmp_valid = 1'b0;
  logic [4:0]  cmp_token = '0;
  logic [1:0]  ret_valid;
  logic [15:0] ret_tag;
  logic [7:0]  ret_uops;
  logic [3:0]  free_count;

  logic        z_ready;
  logic [1:0]  z_token;
  logic [1:0]  z_ret_valid;
  logic [15:0] z_ret_tag;
  logic [1:0]  z_ret_uops;
  logic        z_free;

  always #2.5 clk = ~clk;

  retire_queue #(.ENTRIES(N), .TAG_W(8), .RET_MAX(2)) u_retire_queue (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_tag(disp_tag),
    .disp_uops(disp_uops), .disp_token(disp_token),
    .cmp_valid(cmp_valid), .cmp_token(cmp_token),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_uops(ret_uops),
    .free_count(free_count)
  );

  retire_queue #(.ENTRIES(0), .TAG_W(8), .RET_MAX(2)) u_zero (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(1'b1), .disp_ready(z_ready), .disp_tag(8'h5a),
    .disp_uops(1'b1), .disp_token(z_token),
    .cmp_valid(1'b1), .cmp_token(2'b00),
    .ret_valid(z_ret_valid), .ret_tag(z_ret_tag), .ret_uops(z_ret_uops),
    .free_count(z_free)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int exp_free = N;
  int exp_tail = 0;
  logic [11:0] exp_q [$];
  int retire_cycles = 0;
  int retired = 0;
  int max_lanes = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Scoreboard monitor: retirements must match dispatch order (R6)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int lanes;
      lanes = 0;
      for (int i = 0; i < 2; i++) begin
        if (ret_valid[i]) begin
          logic [11:0] e;
          lanes++;
          if (exp_q.size() == 0) begin
            check(0, "R6 unexpected retire", int'(ret_tag[i*8 +: 8]), -1);
          end else begin
            e = exp_q.pop_front();
            check(ret_tag[i*8 +: 8] == e[11:4], "R6 tag order", int'(ret_tag[i*8 +: 8]), int'(e[11:4]));
            check(ret_uops[i*4 +: 4] == e[3:0], "R6 lane uops", int'(ret_uops[i*4 +: 4]), int'(e[3:0]));
            exp_free += int'(e[3:0]);
          end
        end
      end
      if (lanes > 0) retire_cycles++;
      retired += lanes;
      if (lanes > max_lanes) max_lanes = lanes;
    end
  end

  task automatic dispatch(input logic [7:0] tag, input logic [3:0] u, output int tok);
    @(negedge clk); #1;
    disp_valid = 1'b1; disp_tag = tag; disp_uops = u;
    #0.1;
    while (!disp_ready) begin @(negedge clk); #1; end
    check(disp_token == 5'(exp_tail), "R3 token", int'(disp_token), exp_tail);
    tok = int'(disp_token);
    exp_q.push_back({tag, u});
    exp_free -= int'(u);
    exp_tail = (exp_tail + ((u == 0) ? 1 : int'(u))) % SL;
    @(posedge clk); #1;
    disp_valid = 1'b0;
  endtask

  task automatic complete(input int tok);
    @(negedge clk); #1;
    cmp_valid = 1'b1; cmp_token = 5'(tok);
    @(posedge clk); #1;
    cmp_valid = 1'b0;
  endtask

  task automatic expect_stall(input logic [3:0] u, input string req);
    int f0;
    @(negedge clk); #1;
    f0 = int'(free_count);
    disp_valid = 1'b1; disp_tag = 8'hee; disp_uops = u;
    repeat (3) begin
      #0.1;
      check(!disp_ready, req, int'(disp_ready), 0);
      @(negedge clk); #1;
    end
    check(int'(free_count) == f0, {req, " free held"}, int'(free_count), f0);
    check(disp_token == 5'(exp_tail), {req, " token held"}, int'(disp_token), exp_tail);
    disp_valid = 1'b0;
  endtask

  task automatic quiet_free(input string req);
    repeat (4) @(negedge clk);
    #2;
    check(ret_valid == 2'b00, {req, " quiet"}, int'(ret_valid), 0);
    check(int'(free_count) == exp_free, req, int'(free_count), exp_free);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int ta, tb, tc, td, t0, rc0, rd0;
    int toks [16];
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    disp_uops = 4'd8;
    #0.1;
    check(free_count == 4'd8, "R1 free", int'(free_count), 8);
    check(ret_valid == 2'b00, "R1 no retire", int'(ret_valid), 0);
    check(disp_token == 5'd0, "R1 token", int'(disp_token), 0);
    check(disp_ready, "R1 ready", int'(disp_ready), 1);
    disp_uops = 4'd0;

    // R9 zero-capacity instance
    check(z_token == 2'b11, "R9 unhandled token", int'(z_token), 3);
    check(z_ready && z_ret_valid == 2'b00, "R9 untracked", int'(z_ret_valid), 0);

    // R3 R4 R8: multi, zero and small counts
    dispatch(8'hA1, 4'd3, ta);
    dispatch(8'hB2, 4'd0, tb);
    dispatch(8'hC3, 4'd2, tc);
    check(tb == 3 && tc == 4, "R8 zero-count takes one slot", tc, 4);
    quiet_free("R4 free after dispatch");

    // R6 completion out of order: nothing leaves while head not executed
    complete(tc);
    repeat (3) begin
      @(negedge clk);
      check(ret_valid == 2'b00, "R6 head blocks", int'(ret_valid), 0);
    end
    complete(ta);
    @(negedge clk);
    check(ret_valid == 2'b01, "R6 stops at unexecuted", int'(ret_valid), 1);
    complete(tb);
    @(negedge clk);
    check(ret_valid == 2'b11, "R6 R7 two retire together", int'(ret_valid), 3);
    quiet_free("R4 free restored");

    // R2 back-pressure on capacity and on oversized counts
    expect_stall(4'd9, "R2 oversized");
    dispatch(8'h11, 4'd5, td);
    expect_stall(4'd4, "R2 short credit");
    complete(td);
    quiet_free("R4 after 5-count retire");
    dispatch(8'h22, 4'd4, td);
    complete(td);
    quiet_free("R4 after 4-count retire");

    // R5 completion on the dispatch edge
    @(negedge clk); #1;
    disp_valid = 1'b1; disp_tag = 8'h55; disp_uops = 4'd1;
    cmp_valid = 1'b1; cmp_token = 5'(exp_tail);
    #0.1;
    check(disp_ready, "R5 ready", int'(disp_ready), 1);
    exp_q.push_back({8'h55, 4'd1});
    exp_free -= 1;
    exp_tail = (exp_tail + 1) % SL;
    @(posedge clk); #1;
    disp_valid = 1'b0; cmp_valid = 1'b0;
    @(negedge clk);
    check(ret_valid == 2'b01 && ret_tag[7:0] == 8'h55, "R5 same-cycle complete", int'(ret_tag[7:0]), 85);
    // R5 completion to an empty slot is ignored
    complete((exp_tail + 2) % SL);
    quiet_free("R5 stray completion");
    dispatch(8'h66, 4'd0, t0);
    repeat (3) begin
      @(negedge clk);
      check(ret_valid == 2'b00, "R5 stray not kept", int'(ret_valid), 0);
    end
    complete(t0);
    quiet_free("R5 drained");

    // R8 R7: fill every slot with zero-count instructions, release in reverse
    for (int i = 0; i < 16; i++) dispatch(8'(8'h80 + i), 4'd0, toks[i]);
    check(free_count == 4'd8, "R8 free still full", int'(free_count), 8);
    expect_stall(4'd0, "R8 slots full");
    for (int i = 15; i >= 1; i--) complete(toks[i]);
    rc0 = retire_cycles; rd0 = retired;
    complete(toks[0]);
    repeat (12) @(negedge clk);
    check(retired - rd0 == 16, "R7 all released", retired - rd0, 16);
    check(retire_cycles - rc0 == 8, "R7 two per cycle", retire_cycles - rc0, 8);
    check(max_lanes <= 2, "R7 lane limit", max_lanes, 2);
    quiet_free("R4 final");
    check(exp_q.size() == 0, "R6 scoreboard empty", exp_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule